// File: doc/BRIEF.md
# DMA Channel Request Control Registers

This register bank sits beside the channel engines of a multi-channel DMA controller and holds the per-channel control state that software touches most often. It stores four bitmaps with one bit per channel: request enable, error-interrupt enable, completion pending and error pending. It also stores a small global control word whose bits select the arbitration style and hold or debug behaviour for the arbiter next to it.

Software never rewrites a bitmap as a whole. It writes a channel number into one of eight byte-wide command slots, and that one channel's bit is set or cleared. Read-modify-write sequences, and the races they bring between software threads, are therefore not needed. Two command slots do not change stored state. One sends a one-cycle start pulse to a channel. The other sends a one-cycle done-clear pulse to a channel.

The channel engines report completions and errors as one-cycle pulses on per-channel vectors. The bank combines the pending bits into one transfer interrupt line and one error interrupt line.

Top module: `dma_chreq_regs`

## Requirements
- R1: While reset is asserted, all four bitmaps and the control word are zero, and every output reads low.
- R2: A write to byte 0x1B sets the request-enable bit of the channel held in the low 5 bits of the byte, and a write to byte 0x1A clears that bit. No other channel's bit changes. The request-enable bitmap reads back at word 0x0C and drives `req_en`.
- R3: A write to byte 0x19 sets the error-interrupt-enable bit of the channel held in the low 5 bits, and a write to byte 0x18 clears it. This bitmap reads back at word 0x14.
- R4: A pulse on `done_in[n]` sets bit n of the completion-pending bitmap, which reads back at word 0x24. A write of n to byte 0x1F clears only bit n. If a pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: A pulse on `err_in[n]` sets bit n of the error-pending bitmap, which reads back at word 0x2C. A write of n to byte 0x1E clears only bit n. If a pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: `irq_done` is high exactly when at least one completion-pending bit is set.
- R7: `irq_err` is high exactly when some channel has both its error-pending bit and its error-interrupt-enable bit set.
- R8: A write of n to byte 0x1D raises bit n of `start_pulse` for the one cycle after the write. A write of n to byte 0x1C does the same on `done_clr`. Neither write changes any bitmap.
- R9: Words 0x18 and 0x1C (the command slots) always read as zero. Bus writes to words 0x0C, 0x14, 0x24 and 0x2C are ignored.
- R10: The control word at 0x00 stores bit 1 (debug enable), bit 2 (round-robin channel arbitration), bit 3 (round-robin group arbitration) and bit 5 (halt), and drives each onto its own output. All other bits of the word read zero.
- R11: One bus write can carry several command bytes, one per byte lane, and each lane acts on its own. If one write both sets and clears the same channel's bit, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | AW (6) | Byte address. The word is selected by the bits above bit 1. |
| bus_be | input | 4 | Byte-lane enables. Lane k is byte address word+k. |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| done_in | input | NCH (32) | Completion pulses from the channel engines |
| err_in | input | NCH (32) | Error pulses from the channel engines |
| req_en | output | NCH (32) | Per-channel request enable |
| start_pulse | output | NCH (32) | One-cycle software start, one bit per channel |
| done_clr | output | NCH (32) | One-cycle done-clear, one bit per channel |
| irq_done | output | 1 | Transfer-complete interrupt |
| irq_err | output | 1 | Error interrupt |
| dbg_en | output | 1 | Control word debug-enable bit |
| rr_chan | output | 1 | Round-robin channel arbitration enable |
| rr_group | output | 1 | Round-robin group arbitration enable |
| halt | output | 1 | Control word halt bit |

## Verification
The command slots are exercised with a range of channel bytes, which show the different ways decoding can go wrong:
- The lowest and highest channels, 0 and 31, expose off-by-one and edge errors in decoding.
- Bytes with the upper three bits set show that those bits are ignored.
- Writes that enable two lanes at once show that the lanes act independently, and that set wins when a set and a clear target the same channel.

The completion and error inputs are pulsed on their own and together with a clear of the same channel. This separates "the pulse wins" from "the last one wins." It also shows that a clear reaches only its own channel and no neighbouring bit. The error interrupt is checked with the enable bit both on and off, so a pending bit that is merely present can be told apart from one that is gated onto the interrupt line. Direct writes to the bitmap words, and reads of the command words, confirm that those accesses leave state unchanged and return zero.

// File: rtl/dma_chreq_regs.sv
module dma_chreq_regs #(
  parameter int NCH = 32,
  parameter int AW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [3:0]      bus_be,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NCH-1:0]  done_in,
  input  logic [NCH-1:0]  err_in,
  output logic [NCH-1:0]  req_en,
  output logic [NCH-1:0]  start_pulse,
  output logic [NCH-1:0]  done_clr,
  output logic            irq_done,
  output logic            irq_err,
  output logic            dbg_en,
  output logic            rr_chan,
  output logic            rr_group,
  output logic            halt
);

  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_CTRL = WW'(8'h00 >> 2);
  localparam logic [WW-1:0] W_REQ  = WW'(8'h0C >> 2);
  localparam logic [WW-1:0] W_EEI  = WW'(8'h14 >> 2);
  localparam logic [WW-1:0] W_CMDA = WW'(8'h18 >> 2);
  localparam logic [WW-1:0] W_CMDB = WW'(8'h1C >> 2);
  localparam logic [WW-1:0] W_INT  = WW'(8'h24 >> 2);
  localparam logic [WW-1:0] W_ERR  = WW'(8'h2C >> 2);

  logic [NCH-1:0] req_q, eei_q, int_q, err_q;
  logic [NCH-1:0] lane_a [4];
  logic [NCH-1:0] lane_b [4];
  logic [WW-1:0]  wsel;
  logic           cmd_a, cmd_b;

  function automatic logic [NCH-1:0] chan_hot(input logic [4:0] c);
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = (c == i[4:0]);
    return v;
  endfunction

  assign wsel  = bus_addr[AW-1:2];
  assign cmd_a = bus_wr && (wsel == W_CMDA);
  assign cmd_b = bus_wr && (wsel == W_CMDB);

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_a[k] = (cmd_a && bus_be[k]) ? chan_hot(bus_wdata[8*k +: 5]) : '0;
    assign lane_b[k] = (cmd_b && bus_be[k]) ? chan_hot(bus_wdata[8*k +: 5]) : '0;
  end

  logic unused_bits;
  assign unused_bits = &{bus_addr[1:0], bus_wdata[31:29], bus_wdata[23:21],
                         bus_wdata[15:13], bus_wdata[7:6], bus_wdata[0], bus_wdata[4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0; eei_q <= '0; int_q <= '0; err_q <= '0;
      start_pulse <= '0; done_clr <= '0;
      dbg_en <= 1'b0; rr_chan <= 1'b0; rr_group <= 1'b0; halt <= 1'b0;
    end else begin
      eei_q <= (eei_q & ~lane_a[0]) | lane_a[1];
      req_q <= (req_q & ~lane_a[2]) | lane_a[3];
      done_clr    <= lane_b[0];
      start_pulse <= lane_b[1];
      err_q <= (err_q & ~lane_b[2]) | err_in;
      int_q <= (int_q & ~lane_b[3]) | done_in;
      if (bus_wr && wsel == W_CTRL && bus_be[0]) begin
        dbg_en   <= bus_wdata[1];
        rr_chan  <= bus_wdata[2];
        rr_group <= bus_wdata[3];
        halt     <= bus_wdata[5];
      end
    end
  end

  assign req_en   = req_q;
  assign irq_done = |int_q;
  assign irq_err  = |(err_q & eei_q);

  always_comb begin
    case (wsel)
      W_CTRL:  bus_rdata = {26'b0, halt, 1'b0, rr_group, rr_chan, dbg_en, 1'b0};
      W_REQ:   bus_rdata = 32'(req_q);
      W_EEI:   bus_rdata = 32'(eei_q);
      W_INT:   bus_rdata = 32'(int_q);
      W_ERR:   bus_rdata = 32'(err_q);
      default: bus_rdata = 32'h0;
    endcase
  end

  // R2: a single set-request command changes at most one request bit
  a_r2_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wsel == W_CMDA && bus_be == 4'b1000)
    |=> ($countones(req_q ^ $past(req_q)) <= 1));

  // R4: every completion pulse leaves its pending bit set
  a_r4_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_in) |=> (($past(done_in) & ~int_q) == '0));

  // R6: the transfer interrupt only rises after a completion pulse
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> $past(|done_in));

  // R7: an enabled error pulse raises the error interrupt
  a_r7_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(err_in & eei_q)) && !bus_wr) |=> irq_err);

  // R9: bus writes to the request bitmap word do not change it
  a_r9_bitmap_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wsel == W_REQ) |=> $stable(req_q));

endmodule

// File: tb/dma_chreq_regs_tb_top.sv
module dma_chreq_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] done_in = '0, err_in = '0;
  logic [31:0] req_en, start_pulse, done_clr;
  logic        irq_done, irq_err, dbg_en, rr_chan, rr_group, halt;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chreq_regs #(.NCH(32), .AW(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_in(done_in), .err_in(err_in), .req_en(req_en),
    .start_pulse(start_pulse), .done_clr(done_clr), .irq_done(irq_done),
    .irq_err(irq_err), .dbg_en(dbg_en), .rr_chan(rr_chan),
    .rr_group(rr_group), .halt(halt)
  );

  // {write addr, byte enables, write data, read addr, expected read}
  localparam logic [79:0] VEC [NV] = '{
    {6'h18, 4'b1000, 32'h05000000, 6'h0C, 32'h00000020},  // R2 set ch5
    {6'h18, 4'b1000, 32'h1F000000, 6'h0C, 32'h80000020},  // R2 set ch31
    {6'h18, 4'b0100, 32'h00050000, 6'h0C, 32'h80000000},  // R2 clear ch5
    {6'h18, 4'b1000, 32'hE3000000, 6'h0C, 32'h80000008},  // R2 upper bits ignored
    {6'h18, 4'b0010, 32'h00000700, 6'h14, 32'h00000080},  // R3 set eei ch7
    {6'h18, 4'b0011, 32'h00000907, 6'h14, 32'h00000200},  // R3 R11 two lanes
    {6'h0C, 4'b1111, 32'hFFFFFFFF, 6'h0C, 32'h80000008},  // R9 direct write ignored
    {6'h00, 4'b0001, 32'h000000FF, 6'h00, 32'h0000002E},  // R10 control bits
    {6'h1C, 4'b1111, 32'h01010101, 6'h1C, 32'h00000000},  // R9 command word reads 0
    {6'h18, 4'b0000, 32'h00000000, 6'h18, 32'h00000000},  // R9 command word reads 0
    {6'h18, 4'b1100, 32'h0A0A0000, 6'h0C, 32'h80000408}   // R11 set wins over clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_chk("R1 ctrl", 6'h00, 32'h0);
    rd_chk("R1 req", 6'h0C, 32'h0);
    rd_chk("R1 eei", 6'h14, 32'h0);
    rd_chk("R1 int", 6'h24, 32'h0);
    rd_chk("R1 err", 6'h2C, 32'h0);
    check("R1 outputs", {req_en[0], start_pulse[0], done_clr[0], irq_done, irq_err,
                         dbg_en, rr_chan, rr_group, halt}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][79:74], VEC[i][73:70], VEC[i][69:38]);
      rd_chk($sformatf("vector %0d", i), VEC[i][37:32], VEC[i][31:0]);
    end
    check("R2 req_en port", req_en, 32'h80000408);
    check("R10 outputs", {28'h0, halt, dbg_en, rr_chan, rr_group}, 32'hF);
    do_write(6'h00, 4'b0001, 32'h00000004);
    check("R10 rr_chan only", {28'h0, halt, dbg_en, rr_chan, rr_group}, 32'h2);

    // R4 R6 completion pending
    check("R6 idle", {31'h0, irq_done}, 32'h0);
    @(negedge clk); done_in = 32'h00000011;
    @(negedge clk); done_in = '0;
    rd_chk("R4 pend", 6'h24, 32'h00000011);
    check("R6 irq on", {31'h0, irq_done}, 32'h1);
    @(negedge clk);
    done_in = 32'h00000010; bus_wr = 1'b1; bus_addr = 6'h1C; bus_be = 4'b1000; bus_wdata = 32'h04000000;
    @(negedge clk); done_in = '0; bus_wr = 1'b0; bus_be = '0;
    rd_chk("R4 set wins", 6'h24, 32'h00000011);
    do_write(6'h1C, 4'b1000, 32'h04000000);
    rd_chk("R4 clear one", 6'h24, 32'h00000001);
    check("R6 still on", {31'h0, irq_done}, 32'h1);
    do_write(6'h1C, 4'b1000, 32'h00000000);
    rd_chk("R4 clear ch0", 6'h24, 32'h0);
    check("R6 irq off", {31'h0, irq_done}, 32'h0);

    // R5 R7 error pending, eei holds ch9 only
    @(negedge clk); err_in = 32'h00000004;
    @(negedge clk); err_in = '0;
    rd_chk("R5 pend", 6'h2C, 32'h00000004);
    check("R7 masked", {31'h0, irq_err}, 32'h0);
    @(negedge clk); err_in = 32'h00000200;
    @(negedge clk); err_in = '0;
    check("R7 enabled", {31'h0, irq_err}, 32'h1);
    do_write(6'h1C, 4'b0100, 32'h00090000);
    rd_chk("R5 clear ch9", 6'h2C, 32'h00000004);
    check("R7 off", {31'h0, irq_err}, 32'h0);
    @(negedge clk);
    err_in = 32'h00000004; bus_wr = 1'b1; bus_addr = 6'h1C; bus_be = 4'b0100; bus_wdata = 32'h00020000;
    @(negedge clk); err_in = '0; bus_wr = 1'b0; bus_be = '0;
    rd_chk("R5 set wins", 6'h2C, 32'h00000004);

    // R8 pulses
    do_write(6'h1C, 4'b0010, 32'h00000600);
    check("R8 start", start_pulse, 32'h00000040);
    check("R8 no done_clr", done_clr, 32'h0);
    @(negedge clk);
    check("R8 start one cycle", start_pulse, 32'h0);
    do_write(6'h1C, 4'b0001, 32'h00000001);
    check("R8 done_clr", done_clr, 32'h00000002);
    rd_chk("R8 req unchanged", 6'h0C, 32'h80000408);
    @(negedge clk);
    check("R8 done_clr one cycle", done_clr, 32'h0);

    // R1 reset again mid-run
    rst_n = 1'b0;
    #1;
    rd_chk("R1 req after reset", 6'h0C, 32'h0);
    rd_chk("R1 err after reset", 6'h2C, 32'h0);
    check("R1 irq after reset", {30'h0, irq_done, irq_err}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule